// File: doc/BRIEF.md
# Byte-Serial DAC Frame Transmitter

This block sends one 16-bit converter word over a three-wire serial link (clock, data, active-low frame). The serial engine under it moves only eight bits per transfer, so every word goes out as two byte transfers. The frame line is held low across both transfers and across the idle gap between them, and it is released only after the second byte. The receiver takes the word most significant bit first, on the falling edge of the serial clock.

A configuration input picks the shift order of the byte engine. In native LSB-first mode, the engine shifts the low bit of its buffer out first. Each byte is therefore bit-reversed before it is loaded, so the wire order is still bit 15 down to bit 0. In the other mode, the engine shifts MSB-first and loads the byte unchanged. Three parameters set the serial clock divider (even), the delay from the frame falling edge to the first serial clock, and the length of the gap between the bytes. A host pulses `start` with the word present. It then waits for `done`, or for `busy` to drop.

Top module: `byte_dac_tx`

## Requirements
- R1: After reset, frame_n is 1, sclk is 1, sdata is 0, busy is 0 and done is 0.
- R2: When start is sampled high while idle, frame_n is 0 in the next cycle. The first sclk falling edge comes SETUP_CYC + SCLK_DIV/2 cycles after that cycle.
- R3: Each serial bit lasts SCLK_DIV system cycles. sclk is high for the first half of the bit and low for the second half. A frame holds exactly 16 sclk falling edges, eight per byte.
- R4: The bits sampled at the 16 falling edges are word bits 15 down to 0, in that order, for both lsb_mode values. lsb_mode=1 selects an LSB-first byte engine with each byte bit-reversed before it is loaded. lsb_mode=0 selects an MSB-first engine with no reversal.
- R5: Between the 8th and 9th falling edges there is an extra idle gap of GAP_SCLKS*SCLK_DIV cycles, so the spacing of those two edges is (GAP_SCLKS+1)*SCLK_DIV. sclk stays high and frame_n stays low through the gap.
- R6: sdata changes only while sclk is high. It is stable while sclk is low, so it is valid at each falling edge.
- R7: frame_n stays low for exactly SETUP_CYC + (16+GAP_SCLKS)*SCLK_DIV cycles. It returns high SCLK_DIV/2 cycles after the 16th falling edge.
- R8: busy is 1 exactly while frame_n is 0. done is 1 for one cycle, in the first cycle in which frame_n is high again.
- R9: start pulses while busy are ignored. word_in and lsb_mode are captured at start, so later changes to them do not alter the frame.
- R10: While idle, sclk is held at 1 and sdata at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send word_in |
| word_in | input | 16 | Word to transmit |
| lsb_mode | input | 1 | 1: LSB-first byte engine with pre-reversal; 0: MSB-first engine |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, valid at sclk falling edges |
| frame_n | output | 1 | Active-low frame, low across both bytes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame is released |

## Verification
The bench goes after four ways this block can fail.
- Bit order across the byte boundary in both modes. A missing or doubled reversal delivers each byte mirrored, and a swapped byte select sends the low byte first. Walking-one words and asymmetric patterns expose both.
- Edge timing. The bench measures the distance from the frame fall to the first clock fall, and the spacing of every falling edge. A gap that is too short, or that drops the clock, breaks the 8th-to-9th spacing. A lost or extra bit changes the count of 16 edges.
- The frame release and the done pulse. Releasing early, or pulsing for the wrong cycle, shows up in the measured low time.
- A second start during a frame. Together with changing word_in and lsb_mode mid-frame, this would corrupt the captured word or restart the frame if it were not ignored.

// File: rtl/byte_dac_pkg.sv
package byte_dac_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_e;

    // Byte to transfer for a given position: position 0 is the upper byte.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic second);
        return second ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/byte_dac_sclk_phase.sv
module byte_dac_sclk_phase #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk_low,
    output logic phase_last
);
    localparam int PH_W = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
    localparam int HALF = SCLK_DIV / 2;

    logic [PH_W-1:0] ph_q;

    assign phase_last = (ph_q == PH_W'(SCLK_DIV - 1));
    assign sclk_low   = (ph_q >= PH_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (phase_last) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

    // R3: a bit always ends in its low half.
    p_bit_ends_low_r3: assert property (@(posedge clk) disable iff (rst)
        (run && phase_last) |-> sclk_low);

    // R3: the phase restarts high after the last step of a bit.
    p_phase_wraps_r3: assert property (@(posedge clk) disable iff (rst)
        (run && phase_last) |=> !sclk_low);

endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader
    import byte_dac_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              second,
    input  logic              lsb_first,
    output logic [BYTE_W-1:0] img
);
    logic [BYTE_W-1:0] raw;
    logic [BYTE_W-1:0] mirrored;

    assign raw = pick_byte(word, second);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_mirror
        assign mirrored[i] = raw[BYTE_W-1-i];
    end

    assign img = lsb_first ? mirrored : raw;

endmodule

// File: rtl/byte_dac_shifter.sv
module byte_dac_shifter
    import byte_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] din,
    output logic              sbit
);
    logic [BYTE_W-1:0] img_q;

    assign sbit = lsb_first ? img_q[0] : img_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
        end else if (load) begin
            img_q <= din;
        end else if (shift) begin
            img_q <= lsb_first ? (img_q >> 1) : (img_q << 1);
        end
    end

    // R4: a byte is never loaded and shifted in the same cycle.
    p_no_load_shift_r4: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/byte_dac_tx.sv
module byte_dac_tx
    import byte_dac_pkg::*;
#(
    parameter int SCLK_DIV  = 4,
    parameter int SETUP_CYC = 2,
    parameter int GAP_SCLKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word_in,
    input  logic              lsb_mode,
    output logic              sclk,
    output logic              sdata,
    output logic              frame_n,
    output logic              busy,
    output logic              done
);
    localparam int GAP_CYC  = GAP_SCLKS * SCLK_DIV;
    localparam int WAIT_MAX = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int BIT_W    = $clog2(BYTE_W);

    tx_state_e         state_q;
    logic [WAIT_W-1:0] wait_q;
    logic [BIT_W-1:0]  bit_q;
    logic              second_q;
    logic [WORD_W-1:0] word_q;
    logic              mode_q;
    logic              done_q;

    logic              in_shift;
    logic              sclk_low;
    logic              phase_last;
    logic              last_bit;
    logic              wait_end;
    logic              load;
    logic              shift;
    logic [BYTE_W-1:0] byte_img;
    logic              sbit;

    assign in_shift = (state_q == ST_SHIFT);
    assign last_bit = (bit_q == BIT_W'(BYTE_W - 1));
    assign wait_end = (wait_q == '0);
    assign load     = ((state_q == ST_SETUP) || (state_q == ST_GAP)) && wait_end;
    assign shift    = in_shift && phase_last && !last_bit;

    byte_dac_sclk_phase #(.SCLK_DIV(SCLK_DIV)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .run        (in_shift),
        .sclk_low   (sclk_low),
        .phase_last (phase_last)
    );

    byte_dac_loader u_loader (
        .word      (word_q),
        .second    (second_q),
        .lsb_first (mode_q),
        .img       (byte_img)
    );

    byte_dac_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .shift     (shift),
        .lsb_first (mode_q),
        .din       (byte_img),
        .sbit      (sbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wait_q   <= '0;
            bit_q    <= '0;
            second_q <= 1'b0;
            word_q   <= '0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        word_q   <= word_in;
                        mode_q   <= lsb_mode;
                        second_q <= 1'b0;
                        wait_q   <= WAIT_W'(SETUP_CYC - 1);
                        state_q  <= ST_SETUP;
                    end
                end
                ST_SETUP, ST_GAP: begin
                    if (wait_end) begin
                        bit_q   <= '0;
                        state_q <= ST_SHIFT;
                    end else begin
                        wait_q <= wait_q - WAIT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (phase_last) begin
                        if (!last_bit) begin
                            bit_q <= bit_q + BIT_W'(1);
                        end else if (!second_q) begin
                            second_q <= 1'b1;
                            wait_q   <= WAIT_W'(GAP_CYC - 1);
                            state_q  <= ST_GAP;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign frame_n = !busy;
    assign sclk    = !(in_shift && sclk_low);
    assign sdata   = in_shift && sbit;
    assign done    = done_q;

    // R10: idle line levels.
    p_idle_levels_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && !sdata));

    // R8: done only on the release of a frame.
    p_done_on_release_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_n && $past(busy)));

    // R9: a start during a frame leaves the captured request alone.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(word_q) && $stable(mode_q)));

    // R6: data steady while the clock is low.
    p_data_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!sclk && !$past(sclk)) |-> $stable(sdata));

    // R5: the gap keeps the clock high inside the frame.
    p_gap_high_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |-> (sclk && !frame_n));

    // R2: no clock activity during the frame setup delay.
    p_setup_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP) |-> (sclk && !frame_n));

endmodule

// File: tb/tb_byte_dac_tx.sv
module tb_byte_dac_tx;

    localparam int DIV   = 4;
    localparam int SETUP = 2;
    localparam int GAP   = 1;
    localparam int HALF  = DIV / 2;
    localparam int FRAME_LOW = SETUP + (16 + GAP) * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] word_in = '0;
    logic        lsb_mode = 1'b0;
    logic        sclk, sdata, frame_n, busy, done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    byte_dac_tx #(.SCLK_DIV(DIV), .SETUP_CYC(SETUP), .GAP_SCLKS(GAP)) dut (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in),
        .lsb_mode(lsb_mode), .sclk(sclk), .sdata(sdata),
        .frame_n(frame_n), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected=0", cycles);
                finish_run();
            end
        end
    end

    task automatic send(input logic [15:0] w, input bit m, input bit poke);
        int cyc;
        int nfall;
        int fall_t[16];
        logic [15:0] got;
        logic prev_sclk, prev_sdata;
        bit busy_ok, steady_ok, gap_ok;
        @(negedge clk);
        word_in = w; lsb_mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0; word_in = ~w; lsb_mode = !m;
        check(frame_n == 1'b0, "R2 frame low after start", frame_n, 0);
        cyc = 0; nfall = 0; got = '0;
        busy_ok = 1'b1; steady_ok = 1'b1; gap_ok = 1'b1;
        prev_sclk = 1'b1; prev_sdata = sdata;
        while (frame_n == 1'b0 && cyc < 400) begin
            if (busy != 1'b1) busy_ok = 1'b0;
            if (prev_sclk && !sclk) begin
                if (nfall < 16) fall_t[nfall] = cyc;
                nfall++;
                got = {got[14:0], sdata};
            end
            if (!prev_sclk && !sclk && sdata != prev_sdata) steady_ok = 1'b0;
            if (nfall == 8 && !prev_sclk && sclk) gap_ok = 1'b1;
            if (nfall == 8 && cyc > fall_t[7] + HALF - 1 && !sclk) gap_ok = 1'b0;
            prev_sclk = sclk; prev_sdata = sdata;
            if (poke && cyc == 9)  begin start = 1'b1; word_in = 16'h5A5A ^ w; end
            if (poke && cyc == 10) start = 1'b0;
            if (poke && cyc == 40) begin start = 1'b1; lsb_mode = m; end
            if (poke && cyc == 41) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(nfall == 16, "R3 falling edge count", nfall, 16);
        check(got == w, $sformatf("R4 wire order mode=%0d", m), got, w);
        if (nfall == 16) begin
            check(fall_t[0] == SETUP + HALF, "R2 setup to first fall", fall_t[0], SETUP + HALF);
            for (int k = 1; k < 16; k++) begin
                int exp_d = (k == 8) ? (GAP + 1) * DIV : DIV;
                check(fall_t[k] - fall_t[k-1] == exp_d,
                      (k == 8) ? "R5 gap spacing" : "R3 bit spacing",
                      fall_t[k] - fall_t[k-1], exp_d);
            end
            check(cyc - fall_t[15] == HALF, "R7 release after last fall", cyc - fall_t[15], HALF);
        end
        check(gap_ok, "R5 sclk high in gap", gap_ok, 1);
        check(steady_ok, "R6 data steady while sclk low", steady_ok, 1);
        check(cyc == FRAME_LOW, "R7 frame low length", cyc, FRAME_LOW);
        check(busy_ok, "R8 busy during frame", busy_ok, 1);
        check(done == 1'b1 && busy == 1'b0, "R8 done at release", {done, busy}, 2'b10);
        if (poke) check(got == w, "R9 start while busy ignored", got, w);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", done, 0);
        check(sclk == 1'b1 && sdata == 1'b0 && frame_n == 1'b1, "R10 idle levels",
              {sclk, sdata, frame_n}, 3'b101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(frame_n == 1'b1 && sclk == 1'b1 && sdata == 1'b0 && busy == 1'b0 && done == 1'b0,
              "R1 reset state", {frame_n, sclk, sdata, busy, done}, 5'b11000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(frame_n == 1'b1 && busy == 1'b0 && sclk == 1'b1, "R10 idle after reset",
              {frame_n, busy, sclk}, 3'b101);
        for (int m = 0; m < 2; m++) begin
            send(16'h0000, m[0], 1'b0);
            send(16'hFFFF, m[0], 1'b0);
            send(16'h8001, m[0], 1'b0);
            send(16'h1234, m[0], 1'b0);
            send(16'hA5C3, m[0], 1'b1);
            for (int b = 0; b < 16; b++) begin
                send(16'(1) << b, m[0], 1'b0);
                send(~(16'(1) << b), m[0], b[0]);
            end
        end
        finish_run();
    end

endmodule